// File: doc/BRIEF.md
# Changeover Switch Contact Cleaner

This block takes the two contact lines of a single-pole double-throw switch and turns them into one clean logic level. The common terminal of the switch is grounded and each contact line is pulled up, so a line reads 0 while its contact touches common and 1 while it is open. The block samples both lines on its own clock, passes each through a short synchroniser chain, and then applies a hold rule. The output moves only when the switch sits fully in one of its two end positions. Every in-between combination leaves the output unchanged.

No settling timer is used. One contact qualifies the other, so bounce on either line while the other line disagrees cannot move the output. The hold rule covers both mid-travel combinations, so the same logic works with break-before-make and make-before-break switches. A one-cycle pulse marks each low-to-high change of the output, and it can drive a counter directly.

Top module: `sw_changeover_clean`

## Requirements
- R1: While `rst_n` is sampled low at a clock edge, `level_o` and `rise_o` are 0 after that edge. After reset the output stays 0 until the up combination is seen.
- R2: The up combination (`contact_a_n`=0, `contact_b_n`=1) drives `level_o` to 1.
- R3: The down combination (`contact_a_n`=1, `contact_b_n`=0) drives `level_o` to 0.
- R4: When both lines are 1 (open, mid-travel), `level_o` keeps its value, however often that combination is entered or left.
- R5: When both lines are 0 (both contacts touching), `level_o` keeps its value. It is never forced to 1.
- R6: `rise_o` is 1 for exactly one cycle, the first cycle in which `level_o` is 1 after being 0. At all other times it is 0.
- R7: With the default two synchroniser stages, a new seated combination held on the inputs shows on `level_o` exactly three rising clock edges after it is applied. The opposite seated position is accepted just as fast, with no lockout.
- R8: A full down-to-up travel with any amount of bounce on either contact gives exactly one `rise_o` pulse. A full up-to-down travel gives none.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Sampling clock |
| rst_n | input | 1 | Synchronous reset, active low |
| contact_a_n | input | 1 | Raw first contact, 0 while touching common |
| contact_b_n | input | 1 | Raw second contact, 0 while touching common |
| level_o | output | 1 | Cleaned switch level, 1 for up and 0 for down |
| rise_o | output | 1 | One-cycle pulse on each 0-to-1 change of `level_o` |

## Verification
The bench targets three weak points.

- **Both-contacts-closed combination.** A design that treats it like a gate with a low input would push the output high mid-travel. A down-going make-before-break switch would then produce extra counts.
- **Bounce bursts.** Random bursts are applied on one line at a time and on both lines in step. A design that reacts to a single line would give more than one rise pulse per travel.
- **Output timing.** The exact edge on which the output changes is checked, together with the width of the rise pulse. An extra stage, a missing stage, or a level-based pulse would show up as a shifted or stretched output.

// File: rtl/chg_pkg.sv
// Shared types for the changeover switch cleaner.
// Assumes contact lines are active low: 0 = contact touching common.
package chg_pkg;

    // Switch position classes, encoded as {line_a, line_b}.
    typedef enum logic [1:0] {
        POS_BOTH = 2'b00,   // both contacts touching (make-before-break travel)
        POS_UP   = 2'b01,   // seated up
        POS_DOWN = 2'b10,   // seated down
        POS_OPEN = 2'b11    // neither contact touching (break-before-make travel)
    } pos_e;

    // Map the two synchronised lines onto a position class.
    function automatic pos_e classify(input logic a_n, input logic b_n);
        return pos_e'({a_n, b_n});
    endfunction

endpackage

// File: rtl/chg_sync.sv
// Multi-bit, multi-stage synchroniser chain.
// Each bit passes independently through STAGES flops.
// Assumes the inputs are asynchronous levels. Every stage resets to RST_VAL.
module chg_sync #(
    parameter int unsigned WIDTH   = 2,
    parameter int unsigned STAGES  = 2,
    parameter logic        RST_VAL = 1'b1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] din,
    output logic [WIDTH-1:0] dout
);
    localparam int unsigned LAST = STAGES - 1;

    logic [WIDTH-1:0] stage_q [STAGES];

    // First stage captures the raw lines.
    always_ff @(posedge clk) begin
        if (!rst_n) stage_q[0] <= {WIDTH{RST_VAL}};
        else        stage_q[0] <= din;
    end

    // Further stages each shift the previous one.
    for (genvar s = 1; s < STAGES; s++) begin : g_stage
        always_ff @(posedge clk) begin
            if (!rst_n) stage_q[s] <= {WIDTH{RST_VAL}};
            else        stage_q[s] <= stage_q[s-1];
        end
    end

    assign dout = stage_q[LAST];

endmodule

// File: rtl/chg_hold.sv
// Hold-state decision for a changeover switch.
// Sets the level on the up combination and clears it on the down combination.
// Holds the level on both mid-travel combinations.
// Registers a one-cycle pulse on every 0-to-1 change of the level.
// Assumes both inputs are already synchronous to clk.
module chg_hold
    import chg_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic a_n,
    input  logic b_n,
    output logic level,
    output logic rise
);
    pos_e pos;
    logic level_d;

    // Classify the current contact pair and pick the next level.
    always_comb begin
        pos = classify(a_n, b_n);
        unique case (pos)
            POS_UP:   level_d = 1'b1;
            POS_DOWN: level_d = 1'b0;
            default:  level_d = level;   // POS_OPEN and POS_BOTH hold
        endcase
    end

    // Register the level and the edge pulse together.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            level <= 1'b0;
            rise  <= 1'b0;
        end else begin
            level <= level_d;
            rise  <= level_d & ~level;
        end
    end

endmodule

// File: rtl/sw_changeover_clean.sv
// Top level of the changeover switch cleaner.
// Synchronises both raw contact lines, then applies the hold-state decision.
// Assumes active-low contacts on a grounded common terminal.
// Synchroniser flops reset to the open state (1), so they cannot trigger a change on their own.
module sw_changeover_clean #(
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic contact_a_n,
    input  logic contact_b_n,
    output logic level_o,
    output logic rise_o
);
    logic [1:0] raw_pair;
    logic [1:0] sync_pair;
    logic       a_sync;
    logic       b_sync;

    assign raw_pair = {contact_a_n, contact_b_n};

    chg_sync #(
        .WIDTH   (2),
        .STAGES  (SYNC_STAGES),
        .RST_VAL (1'b1)
    ) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .din   (raw_pair),
        .dout  (sync_pair)
    );

    assign a_sync = sync_pair[1];
    assign b_sync = sync_pair[0];

    chg_hold u_hold (
        .clk   (clk),
        .rst_n (rst_n),
        .a_n   (a_sync),
        .b_n   (b_sync),
        .level (level_o),
        .rise  (rise_o)
    );

endmodule

// File: rtl/sw_changeover_clean_chk.sv
// Property checker for sw_changeover_clean, attached through bind.
// It observes the synchronised contact pair and the two outputs.
module sw_changeover_clean_chk (
    input logic clk,
    input logic rst_n,
    input logic a_s,
    input logic b_s,
    input logic level,
    input logic rise
);
    // R1
    reset_clear_chk: assert property (@(posedge clk) !rst_n |=> (!level && !rise));

    // R2
    up_sets_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!a_s && b_s) |=> level);

    // R3
    down_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (a_s && !b_s) |=> !level);

    // R4
    open_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (a_s && b_s) |=> $stable(level));

    // R5
    both_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!a_s && !b_s) |=> $stable(level));

    // R6
    rise_on_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(level) |-> rise);

    // R6
    rise_only_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rise |-> (level && !$past(level)));

endmodule

bind sw_changeover_clean sw_changeover_clean_chk u_chk (
    .clk   (clk),
    .rst_n (rst_n),
    .a_s   (a_sync),
    .b_s   (b_sync),
    .level (level_o),
    .rise  (rise_o)
);

// File: tb/sw_changeover_clean_bench.sv
module sw_changeover_clean_bench;
    localparam time CLK_PERIOD = 10ns;
    localparam int  LAT        = 3;
    localparam int  N_STEPS    = 12;

    // Each entry is {contact_a_n, contact_b_n, expected level}.
    localparam logic [2:0] STEP_TBL [N_STEPS] = '{
        3'b110,   // open after reset: stays low (R1, R4)
        3'b000,   // both closed: not forced high (R5)
        3'b011,   // up (R2)
        3'b111,   // open: hold high (R4)
        3'b001,   // both closed: hold high (R5)
        3'b100,   // down (R3)
        3'b000,   // both closed: hold low (R5)
        3'b110,   // open: hold low (R4)
        3'b011,   // up (R2)
        3'b100,   // down (R3)
        3'b011,   // up (R2)
        3'b100    // down (R3)
    };

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic a_n = 1'b1;
    logic b_n = 1'b1;
    logic level_o;
    logic rise_o;

    int checks = 0;
    int errors = 0;
    int rise_cnt = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    sw_changeover_clean u_sw_changeover_clean (
        .clk         (clk),
        .rst_n       (rst_n),
        .contact_a_n (a_n),
        .contact_b_n (b_n),
        .level_o     (level_o),
        .rise_o      (rise_o)
    );

    // Count rise pulses once per cycle, away from the active edge.
    always @(negedge clk) if (rise_o === 1'b1) rise_cnt++;

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic settle();
        repeat (LAT + 1) @(negedge clk);
    endtask

    task automatic drive(input logic a, input logic b);
        @(negedge clk);
        a_n = a;
        b_n = b;
    endtask

    // Random bounce on one line while the other line is held, ending at a final value.
    task automatic bounce_one(input bit on_a, input logic hold_v, input logic final_v);
        int n = 3 + ($urandom % 8);
        for (int k = 0; k < n; k++) begin
            if (on_a) drive(1'($urandom), hold_v);
            else      drive(hold_v, 1'($urandom));
        end
        if (on_a) drive(final_v, hold_v);
        else      drive(hold_v, final_v);
    endtask

    // Random bounce on both lines together, moving between the two held combinations.
    task automatic bounce_pair();
        int n = 4 + ($urandom % 8);
        for (int k = 0; k < n; k++) begin
            logic v = 1'($urandom);
            drive(v, v);
        end
    endtask

    // Full travel; mbb selects make-before-break, otherwise break-before-make.
    task automatic travel(input bit up, input bit mbb);
        int start = rise_cnt;
        if (up) begin
            if (mbb) begin bounce_one(1, 1'b0, 1'b0); bounce_one(0, 1'b0, 1'b1); end
            else     begin bounce_one(0, 1'b1, 1'b1); bounce_one(1, 1'b1, 1'b0); end
        end else begin
            if (mbb) begin bounce_one(0, 1'b0, 1'b0); bounce_one(1, 1'b0, 1'b1); end
            else     begin bounce_one(1, 1'b1, 1'b1); bounce_one(0, 1'b1, 1'b0); end
        end
        settle();
        check("R8 rise count per travel", rise_cnt - start, up ? 1 : 0);
        check(up ? "R8 level after up travel" : "R8 level after down travel",
              int'(level_o), up ? 1 : 0);
    endtask

    // Watchdog: a hung run is counted as a failure.
    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected finish");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        logic prev_exp;
        int   start;

        // R1: reset state
        repeat (3) @(negedge clk);
        check("R1 level in reset", int'(level_o), 0);
        check("R1 rise in reset", int'(rise_o), 0);
        rst_n = 1'b1;
        settle();
        check("R1 level after reset", int'(level_o), 0);

        // Table walk
        prev_exp = 1'b0;
        for (int i = 0; i < N_STEPS; i++) begin
            start = rise_cnt;
            drive(STEP_TBL[i][2], STEP_TBL[i][1]);
            settle();
            check("R2/R3/R4/R5 table level", int'(level_o), int'(STEP_TBL[i][0]));
            check("R6 table rise count", rise_cnt - start,
                  (STEP_TBL[i][0] && !prev_exp) ? 1 : 0);
            prev_exp = STEP_TBL[i][0];
        end

        // R7: exact latency, then immediate acceptance of the opposite position
        drive(1'b0, 1'b1);
        @(negedge clk); check("R7 no change after one edge", int'(level_o), 0);
        @(negedge clk); check("R7 no change after two edges", int'(level_o), 0);
        @(negedge clk); check("R7 high after three edges", int'(level_o), 1);
        check("R6 rise with first high cycle", int'(rise_o), 1);
        a_n = 1'b1; b_n = 1'b0;   // down applied at once, on this negedge
        @(negedge clk); check("R6 rise lasts one cycle", int'(rise_o), 0);
        check("R7 still high one edge after down", int'(level_o), 1);
        @(negedge clk); check("R7 still high two edges after down", int'(level_o), 1);
        @(negedge clk); check("R7 low three edges after down", int'(level_o), 0);
        check("R6 no rise on fall", int'(rise_o), 0);

        // R8: bounce travel, both switch types, with held bursts in between
        for (int t = 0; t < 6; t++) begin
            travel(1'b1, t[0]);
            start = rise_cnt;
            bounce_pair();
            settle();
            check("R4/R5 paired bounce holds high", int'(level_o), 1);
            check("R8 no rise during paired bounce", rise_cnt - start, 0);
            travel(1'b0, t[1]);
            bounce_pair();
            settle();
            check("R4/R5 paired bounce holds low", int'(level_o), 0);
        end

        // R1: reset while high clears the output, which then stays low while open
        drive(1'b0, 1'b1);
        settle();
        check("R2 up before reset", int'(level_o), 1);
        drive(1'b1, 1'b1);
        rst_n = 1'b0;
        @(negedge clk); @(negedge clk);
        check("R1 reset clears high level", int'(level_o), 0);
        rst_n = 1'b1;
        settle();
        check("R1 stays low after reset while open", int'(level_o), 0);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule